// File: doc/BRIEF.md
# Display Card Control and Interrupt Register

This block is the processor-facing register port of a display card on a 16-bit asynchronous bus. The bus signals are a chip select, separate upper and lower byte strobes, a read/write line and a word address. The select and both strobes are first re-timed into the local clock domain through a flip-flop synchronizer. Only the re-timed copies are used inside, so every part of the logic reacts to the same select edge.

Each access inside the card's window is answered by a one that walks down a short shift register. When the one reaches the last tap, the transfer acknowledge is asserted. It stays asserted until the select goes away. The two control registers sit on the lower byte lane. The register at word 0 (byte offset 1) reads back a fixed identification byte, and any write to it clears the pending interrupt. The register at word 1 (byte offset 3) holds a three-bit interrupt level, an enable and a pending flag. The block presents the programmed level on a three-bit request output while an enabled interrupt is pending. Words 2 and above belong to the identification/font ROM. Those accesses are acknowledged but have no effect on the registers.

Top module: `dispRegIf`

## Requirements
- R1: After reset the acknowledge `busAckN` is high, `irqLevel` is 000, `busRdEn` is low, and the configuration register reads 0x00.
- R2: Select and strobes pass through two synchronizing flip-flops before use. The acknowledge is driven low on the 7th rising clock edge after the select and a strobe go low. That count is 2 synchronizer edges, 4 walking-one stages and 1 acknowledge register.
- R3: Once low, `busAckN` stays low while the select is held. It returns high on the 3rd rising edge after the select goes high.
- R4: A read of word 0 on the lower lane returns the identification byte (parameter, default 0xA5) on `busRdData`.
- R5: A lower-lane write of any value to word 0 clears the pending flag.
- R6: A lower-lane write to word 1 loads the level from data bits 5:3 (bit 3 is the LSB) and the enable from bit 7. Data bits 6 and 2:0 are ignored.
- R7: A read of word 1 returns enable in bit 7, pending in bit 6, the level in bits 5:3, and zeros in bits 2:0.
- R8: The pending flag sets on a rising edge of `ctlIrqIn` and not on a held high level. It stays set until cleared as in R5. When a set and a clear occur in the same cycle, the set wins.
- R9: `irqLevel` equals the programmed level while both enable and pending are 1, and is 000 otherwise.
- R10: Accesses to words 2 and above (ROM region) are acknowledged with the same timing as R2. They change no register and keep `busRdEn` low.
- R11: An access to word 0 or 1 with only the upper strobe active is acknowledged but changes no register.
- R12: `busRdEn` is high only while the acknowledge is low during a lower-lane read of word 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local (display controller) clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busCsN | input | 1 | Bus chip select, active low, asynchronous |
| busUdsN | input | 1 | Upper byte strobe, active low, asynchronous |
| busLdsN | input | 1 | Lower byte strobe, active low, asynchronous |
| busRwN | input | 1 | 1 = read, 0 = write |
| busWordAddr | input | WORD_W (13) | Word address within the card window |
| busWrData | input | 8 | Lower-lane write data |
| busRdData | output | 8 | Lower-lane read data, valid while busRdEn is high |
| busRdEn | output | 1 | Register read data being driven |
| busAckN | output | 1 | Transfer acknowledge, active low |
| ctlIrqIn | input | 1 | Interrupt request from the display controller (local clock domain) |
| irqLevel | output | 3 | Requested interrupt level, 000 = none |

## Verification
A wrong walking-one chain or synchronizer depth shows up as the acknowledge moving by one or more edges from the 7th, on the first access. A chain that fails to clear shows up as an acknowledge that never releases or fires twice. A bad pending or enable state reaches `irqLevel` in the cycle after the edge that caused it. A misplaced field or an unmasked write bit shows up at the next read-back of the configuration register. For this reason the bench compares the acknowledge, read enable, read data and interrupt level against a behavioural model on every clock.

// File: rtl/dispRegPkg.sv
package dispRegPkg;

  localparam int DATA_W   = 8;
  localparam int LVL_W    = 3;
  localparam int LVL_LSB  = 3;
  localparam int PEND_BIT = 6;
  localparam int EN_BIT   = 7;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrPend;  // write to identification word: clear pending
    logic ldCfg;    // write to configuration word
    logic rdEn;     // register read data is being driven
    logic rdCfg;    // read selects configuration word (else ID)
  } ctlStrobes_t;

endpackage

// File: rtl/dispSync.sv
module dispSync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stg[0] <= '0;
          else       stg[0] <= din;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stg[g] <= '0;
          else       stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/dispCtrl.sv
module dispCtrl
  import dispRegPkg::*;
#(
  parameter int WORD_W    = 13,
  parameter int CHAIN_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selS,
  input  logic              ldsS,
  input  logic              rwN,
  input  logic [WORD_W-1:0] wordAddr,
  output logic              ackQ,
  output ctlStrobes_t       strobes
);

  localparam logic [WORD_W-1:0] ID_WORD  = WORD_W'(0);
  localparam logic [WORD_W-1:0] CFG_WORD = WORD_W'(1);

  logic [CHAIN_LEN-1:0] chain;
  logic served;
  logic start;
  logic tap;
  logic hitId;
  logic hitCfg;
  logic wrCommit;

  assign start    = selS & ~served;
  assign tap      = chain[CHAIN_LEN-1];
  assign hitId    = (wordAddr == ID_WORD);
  assign hitCfg   = (wordAddr == CFG_WORD);
  assign wrCommit = tap & selS & ~rwN & ldsS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain  <= '0;
      served <= 1'b0;
      ackQ   <= 1'b0;
    end else begin
      chain  <= selS ? {chain[CHAIN_LEN-2:0], start} : '0;
      served <= selS & (served | start);
      ackQ   <= selS & (ackQ | tap);
    end
  end

  always_comb begin
    strobes.clrPend = wrCommit & hitId;
    strobes.ldCfg   = wrCommit & hitCfg;
    strobes.rdEn    = ackQ & rwN & ldsS & (hitId | hitCfg);
    strobes.rdCfg   = hitCfg;
  end

  AST_CHAIN_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chain)); // R2

  AST_ACK_FROM_TAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackQ) |-> $past(tap)); // R2

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !selS |=> !ackQ); // R3

  AST_RDEN_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdEn |-> ackQ); // R12

endmodule

// File: rtl/dispDatapath.sv
module dispDatapath
  import dispRegPkg::*;
#(
  parameter logic [DATA_W-1:0] ID_CODE = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ctlIrqIn,
  output logic [DATA_W-1:0] rdData,
  output logic [LVL_W-1:0]  irqLevel
);

  logic              cfgEn;
  logic              pending;
  logic [LVL_W-1:0]  level;
  logic              irqPrev;
  logic              irqRise;
  logic [DATA_W-1:0] cfgByte;
  logic              unusedWrBits;

  assign irqRise      = ctlIrqIn & ~irqPrev;
  assign unusedWrBits = ^{wrData[PEND_BIT], wrData[LVL_LSB-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEn   <= 1'b0;
      level   <= '0;
      pending <= 1'b0;
      irqPrev <= 1'b0;
    end else begin
      irqPrev <= ctlIrqIn;
      if (strobes.ldCfg) begin
        cfgEn <= wrData[EN_BIT];
        level <= wrData[LVL_LSB +: LVL_W];
      end
      if (irqRise)              pending <= 1'b1;
      else if (strobes.clrPend) pending <= 1'b0;
    end
  end

  always_comb begin
    cfgByte                    = '0;
    cfgByte[EN_BIT]            = cfgEn;
    cfgByte[PEND_BIT]          = pending;
    cfgByte[LVL_LSB +: LVL_W]  = level;
  end

  assign rdData   = strobes.rdEn ? (strobes.rdCfg ? cfgByte : ID_CODE) : '0;
  assign irqLevel = (cfgEn & pending) ? level : '0;

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctlIrqIn) |=> pending); // R8

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrPend && !$rose(ctlIrqIn)) |=> !pending); // R5

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.ldCfg |=> ($stable(level) && $stable(cfgEn))); // R6

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgEn && pending) |-> (irqLevel == '0)); // R9

endmodule

// File: rtl/dispRegIf.sv
module dispRegIf
  import dispRegPkg::*;
#(
  parameter int                WORD_W      = 13,
  parameter int                CHAIN_LEN   = 4,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] ID_CODE     = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busCsN,
  input  logic              busUdsN,
  input  logic              busLdsN,
  input  logic              busRwN,
  input  logic [WORD_W-1:0] busWordAddr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic              busRdEn,
  output logic              busAckN,
  input  logic              ctlIrqIn,
  output logic [2:0]        irqLevel
);

  localparam int SYNC_W = 3;

  logic [SYNC_W-1:0] syncOut;
  logic csS, udsS, ldsS, selS;
  logic ackQ;
  ctlStrobes_t strobes;

  dispSync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({~busCsN, ~busUdsN, ~busLdsN}),
    .dout (syncOut)
  );

  assign csS  = syncOut[2];
  assign udsS = syncOut[1];
  assign ldsS = syncOut[0];
  assign selS = csS & (udsS | ldsS);

  dispCtrl #(.WORD_W(WORD_W), .CHAIN_LEN(CHAIN_LEN)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .selS     (selS),
    .ldsS     (ldsS),
    .rwN      (busRwN),
    .wordAddr (busWordAddr),
    .ackQ     (ackQ),
    .strobes  (strobes)
  );

  dispDatapath #(.ID_CODE(ID_CODE)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (busWrData),
    .ctlIrqIn (ctlIrqIn),
    .rdData   (busRdData),
    .irqLevel (irqLevel)
  );

  assign busAckN = ~ackQ;
  assign busRdEn = strobes.rdEn;

endmodule

// File: tb/test_dispRegIf.sv
module test_dispRegIf;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 13;
  localparam int CHAIN      = 4;
  localparam logic [7:0] ID = 8'hA5;
  localparam int WD_LIMIT   = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busCsN = 1'b1, busUdsN = 1'b1, busLdsN = 1'b1, busRwN = 1'b1;
  logic [WORD_W-1:0] busWordAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic busRdEn, busAckN;
  logic ctlIrqIn = 1'b0;
  logic [2:0] irqLevel;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  bit done = 0;

  dispRegIf i_dispRegIf (
    .clk(clk), .rstN(rstN), .busCsN(busCsN), .busUdsN(busUdsN),
    .busLdsN(busLdsN), .busRwN(busRwN), .busWordAddr(busWordAddr),
    .busWrData(busWrData), .busRdData(busRdData), .busRdEn(busRdEn),
    .busAckN(busAckN), .ctlIrqIn(ctlIrqIn), .irqLevel(irqLevel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  int mCnt;
  bit mAck, mS1, mS2, mL1, mL2, mEn, mPend, mPrev;
  bit [2:0] mLvl;

  always @(posedge clk) begin : model
    bit selRaw, rise, wr;
    if (!rstN) begin
      mCnt = 0; mAck = 0; mS1 = 0; mS2 = 0; mL1 = 0; mL2 = 0;
      mEn = 0; mPend = 0; mPrev = 0; mLvl = 0;
    end else begin
      selRaw = !busCsN && (!busUdsN || !busLdsN);
      rise = ctlIrqIn && !mPrev;
      mPrev = ctlIrqIn;
      wr = mS2 && (mCnt == CHAIN) && !busRwN && mL2;
      if (wr && busWordAddr == 1) begin
        mEn = busWrData[7];
        mLvl = busWrData[5:3];
      end
      if (rise) mPend = 1;
      else if (wr && busWordAddr == 0) mPend = 0;
      if (mS2) begin
        mAck = mAck || (mCnt == CHAIN);
        if (mCnt < CHAIN + 1) mCnt++;
      end else begin
        mAck = 0;
        mCnt = 0;
      end
      mS2 = mS1; mS1 = selRaw;
      mL2 = mL1; mL1 = !busLdsN;
    end
  end

  // Per-clock comparison away from the active edge
  always @(negedge clk) begin : compare
    bit expRd;
    if (rstN && !done) begin
      expRd = mAck && busRwN && mL2 && (busWordAddr < 2);
      chk("R2/R3 busAckN", busAckN, !mAck);
      chk("R9 irqLevel", irqLevel, (mEn && mPend) ? mLvl : 3'd0);
      chk("R12 busRdEn", busRdEn, expRd);
      if (expRd)
        chk("R4/R7 busRdData", busRdData,
            (busWordAddr == 0) ? ID : {mEn, mPend, mLvl, 3'b000});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT && !done) begin
      done = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WD_LIMIT);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  // One bus access; riseAt >= 0 raises ctlIrqIn at that negedge count
  task automatic access(input bit rd, input int word, input logic [7:0] wd,
                        input bit lds, input bit uds, input int riseAt,
                        output logic [7:0] rdv, output bit rdEnSeen, output int edges);
    @(negedge clk);
    busWordAddr = word[WORD_W-1:0]; busRwN = rd; busWrData = wd;
    busCsN = 0; busLdsN = !lds; busUdsN = !uds;
    edges = 0;
    while (busAckN && edges < 50) begin
      @(negedge clk);
      edges++;
      if (edges == riseAt) ctlIrqIn = 1;
    end
    rdv = busRdData;
    rdEnSeen = busRdEn;
    busCsN = 1; busLdsN = 1; busUdsN = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R3 ack held 2 edges after release", busAckN, 1'b0);
    @(negedge clk);
    chk("R3 ack released on 3rd edge", busAckN, 1'b1);
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] rv;
    bit re;
    int e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset ack", busAckN, 1'b1);
    chk("R1 reset irqLevel", irqLevel, 3'd0);
    chk("R1 reset rdEn", busRdEn, 1'b0);

    access(1, 0, 8'h00, 1, 0, -1, rv, re, e);
    chk("R4 ID read", rv, ID);
    chk("R2 ack on 7th edge", e, 7);
    chk("R12 rdEn on ID read", re, 1'b1);

    access(1, 1, 8'h00, 1, 0, -1, rv, re, e);
    chk("R1 cfg after reset", rv, 8'h00);

    access(0, 1, 8'hFF, 1, 1, -1, rv, re, e);
    chk("R12 rdEn low on write", re, 1'b0);
    access(1, 1, 8'h00, 1, 0, -1, rv, re, e);
    chk("R6 cfg write masks bits 6,2:0", rv, 8'hB8);
    chk("R9 no request without pending", irqLevel, 3'd0);

    @(negedge clk); ctlIrqIn = 1;
    @(negedge clk);
    chk("R8 pending on rising edge", irqLevel, 3'd7);
    access(1, 1, 8'h00, 1, 0, -1, rv, re, e);
    chk("R7 cfg read with pending", rv, 8'hF8);

    access(0, 0, 8'h3C, 1, 0, -1, rv, re, e);
    chk("R5 clear via ID write", irqLevel, 3'd0);
    repeat (4) @(negedge clk);
    chk("R8 held level does not re-set", irqLevel, 3'd0);
    ctlIrqIn = 0;
    @(negedge clk); ctlIrqIn = 1;
    @(negedge clk);
    chk("R8 new edge sets pending", irqLevel, 3'd7);
    ctlIrqIn = 0;

    access(0, 1, 8'h50, 1, 0, -1, rv, re, e);
    chk("R9 disabled gives 000", irqLevel, 3'd0);
    access(1, 1, 8'h00, 1, 0, -1, rv, re, e);
    chk("R7 cfg level 2 enable 0", rv, 8'h50);

    access(0, 1, 8'h9F, 0, 1, -1, rv, re, e);
    chk("R11 upper-only access acked", e, 7);
    access(1, 1, 8'h00, 1, 0, -1, rv, re, e);
    chk("R11 upper-only write ignored", rv, 8'h50);

    access(1, 128, 8'h00, 1, 1, -1, rv, re, e);
    chk("R10 ROM read acked on 7th edge", e, 7);
    chk("R10 ROM read rdEn low", re, 1'b0);
    access(0, 2, 8'hFF, 1, 1, -1, rv, re, e);
    access(1, 1, 8'h00, 1, 0, -1, rv, re, e);
    chk("R10 ROM write leaves cfg", rv, 8'h50);

    access(0, 1, 8'h88, 1, 0, -1, rv, re, e);
    chk("R9 level 1 enabled pending", irqLevel, 3'd1);
    access(0, 0, 8'h00, 1, 0, -1, rv, re, e);
    chk("R5 cleared before race", irqLevel, 3'd0);
    access(0, 0, 8'hFF, 1, 0, 6, rv, re, e);
    chk("R8 set wins over same-cycle clear", irqLevel, 3'd1);
    ctlIrqIn = 0;

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule